// File: doc/BRIEF.md
# Issue-Group Register Dependency Checker

This block sits in the issue stage of a superscalar core. Each cycle it receives a group of decoded instructions in program order. Every slot carries two source register specifiers, one destination specifier and valid bits. Renaming has already removed the write-after-write and write-after-read hazards, so only true read-after-write dependencies inside the group are checked. For each slot, the block tests both sources against the destination of every older slot in the same group. An N-wide group therefore uses N² − N comparators: slot i needs 2·i of them, and slot 0 needs none.

The block has no clock. It reports three things. For each slot, a hazard flag. For each slot, a one-hot vector that names the older slot producing the value the slot depends on. For the whole group, an issue count: the number of leading slots that may issue this cycle. The issue logic sends slots 0 up to issue count − 1 and holds back the first dependent slot and every slot after it.

Top module: `dep_issue_check`

## Requirements
- R1: Slot i flags a hazard when its first source equals the destination of some older slot j < i, with all relevant valid bits set.
- R2: Slot i flags a hazard when its second source equals the destination of some older slot j < i, with all relevant valid bits set.
- R3: Slot 0 never flags a hazard, even when its sources equal its own destination or the destinations of younger slots.
- R4: A comparison counts only when all of these bits are set:
  - the valid bit of the reading slot;
  - the valid bit of that source;
  - the valid bit of the older slot;
  - the destination-valid bit of the older slot.

  A slot whose own valid bit is clear shows no hazard and no producer.
- R5: Younger slots never cause a hazard for older slots. Two slots that share a destination cause no hazard, so write-after-read and write-after-write cases are ignored.
- R6: For slot i, bits i·N up to i·N+N−1 of `producer` form slot i's producer vector:
  - The vector has at most one bit set.
  - The set bit is at position j, the youngest older slot that matches either source.
  - The vector is zero when there is no hazard.
  - Bits at positions ≥ i are always zero.
- R7: `issue_cnt` equals the index of the lowest slot with a hazard. It equals N when no slot has a hazard.
- R8: The outputs are purely combinational. They follow the inputs within the same time step, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_vld | input | N | Slot holds a real instruction |
| src_a | input | N*W | First source specifier per slot; slot k is at bits k*W up to k*W+W−1 |
| src_a_vld | input | N | First source is used |
| src_b | input | N*W | Second source specifier per slot |
| src_b_vld | input | N | Second source is used |
| dst | input | N*W | Destination specifier per slot |
| dst_vld | input | N | Slot writes a register |
| hazard | output | N | Slot depends on an older slot in the group |
| producer | output | N*N | Per-slot one-hot vector naming the youngest older producer |
| issue_cnt | output | $clog2(N+1) | Length of the dependency-free leading run of slots |

## Verification
The hardest situation to reach is a slot whose sources match several older slots at once. This must be combined with gating bits that suppress some of those matches, because only then does the choice of the youngest producer become visible. Uniform random specifiers over 64 registers almost never produce such collisions. For this reason, the stimulus draws specifiers from a pool of four registers and sets each valid bit with high but incomplete probability, which makes multi-producer and partly gated cases common. A directed sweep then walks every reader/producer slot pair for each source, with and without each gating bit.

// File: rtl/dep_chk_pkg.sv
package dep_chk_pkg;
  parameter int unsigned DEP_GROUP_N = 4;
  parameter int unsigned DEP_REG_W   = 6;
endpackage

// File: rtl/dep_src_match.sv
// Compares one source of slot IDX against the destinations of all older slots.
module dep_src_match #(
  parameter int unsigned N   = 4,
  parameter int unsigned W   = 6,
  parameter int unsigned IDX = 0
) (
  input  logic [W-1:0]   src,
  input  logic           src_ok,
  input  logic [N*W-1:0] dst,
  input  logic [N-1:0]   dst_ok,
  output logic [N-1:0]   hit_vec
);
  for (genvar j = 0; j < N; j++) begin : g_cmp
    if (j < IDX) begin : g_older
      assign hit_vec[j] = src_ok & dst_ok[j] & (dst[j*W +: W] == src);
    end else begin : g_none
      assign hit_vec[j] = 1'b0;
    end
  end
endmodule

// File: rtl/dep_youngest_pick.sv
// Keeps only the highest set bit (youngest older slot).
module dep_youngest_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] match_vec,
  output logic [N-1:0] pick_vec
);
  always_comb begin
    pick_vec = '0;
    for (int j = 0; j < N; j++) begin
      if (match_vec[j]) begin
        pick_vec    = '0;
        pick_vec[j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dep_prefix_enc.sv
// Index of the lowest set bit, or N when none is set.
module dep_prefix_enc #(
  parameter int unsigned N  = 4,
  parameter int unsigned CW = 3
) (
  input  logic [N-1:0]  hit,
  output logic [CW-1:0] count
);
  always_comb begin
    count = CW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) count = CW'(i);
    end
  end
endmodule

// File: rtl/dep_issue_check.sv
module dep_issue_check
  import dep_chk_pkg::*;
#(
  parameter int unsigned N  = DEP_GROUP_N,
  parameter int unsigned W  = DEP_REG_W,
  localparam int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]   inst_vld,
  input  logic [N*W-1:0] src_a,
  input  logic [N-1:0]   src_a_vld,
  input  logic [N*W-1:0] src_b,
  input  logic [N-1:0]   src_b_vld,
  input  logic [N*W-1:0] dst,
  input  logic [N-1:0]   dst_vld,
  output logic [N-1:0]   hazard,
  output logic [N*N-1:0] producer,
  output logic [CW-1:0]  issue_cnt
);
  logic [N-1:0] wr_ok;
  assign wr_ok = inst_vld & dst_vld;

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [N-1:0] hit_a, hit_b, hit_any, pick;

    dep_src_match #(.N(N), .W(W), .IDX(i)) u_match_a (
      .src    (src_a[i*W +: W]),
      .src_ok (inst_vld[i] & src_a_vld[i]),
      .dst    (dst),
      .dst_ok (wr_ok),
      .hit_vec(hit_a)
    );

    dep_src_match #(.N(N), .W(W), .IDX(i)) u_match_b (
      .src    (src_b[i*W +: W]),
      .src_ok (inst_vld[i] & src_b_vld[i]),
      .dst    (dst),
      .dst_ok (wr_ok),
      .hit_vec(hit_b)
    );

    assign hit_any = hit_a | hit_b;

    dep_youngest_pick #(.N(N)) u_pick (
      .match_vec(hit_any),
      .pick_vec (pick)
    );

    assign hazard[i]            = |hit_any;
    assign producer[i*N +: N]   = pick;
  end

  dep_prefix_enc #(.N(N), .CW(CW)) u_prefix (
    .hit  (hazard),
    .count(issue_cnt)
  );
endmodule

// File: rtl/dep_issue_check_sva.sv
module dep_issue_check_sva #(
  parameter int unsigned N  = 4,
  parameter int unsigned W  = 6,
  localparam int unsigned CW = $clog2(N + 1)
) (
  input logic [N-1:0]   inst_vld,
  input logic [N-1:0]   hazard,
  input logic [N*N-1:0] producer,
  input logic [CW-1:0]  issue_cnt
);
  always_comb begin
    AST_SLOT0_CLEAR: assert (!hazard[0]); // R3
    AST_CNT_RANGE: assert (int'(issue_cnt) <= N); // R7
    for (int i = 0; i < N; i++) begin
      AST_PRODUCER_ONEHOT: assert ($onehot0(producer[i*N +: N])); // R6
      AST_HAZARD_HAS_PRODUCER: assert (hazard[i] == (|producer[i*N +: N])); // R6
      AST_INVALID_QUIET: assert (inst_vld[i] || !hazard[i]); // R4
      AST_PREFIX_CLEAN: assert (i >= int'(issue_cnt) || !hazard[i]); // R7
      AST_PREFIX_STOP: assert (i != int'(issue_cnt) || hazard[i]); // R7
      for (int j = 0; j < N; j++) begin
        AST_OLDER_ONLY: assert (j < i || !producer[i*N + j]); // R5
        AST_PRODUCER_VALID: assert (inst_vld[j] || !producer[i*N + j]); // R4
      end
    end
  end
endmodule

bind dep_issue_check dep_issue_check_sva #(.N(N), .W(W)) u_sva (
  .inst_vld (inst_vld),
  .hazard   (hazard),
  .producer (producer),
  .issue_cnt(issue_cnt)
);

// File: tb/dep_issue_check_test.sv
`timescale 1ns/1ps
module dep_issue_check_test;
  localparam int N  = 4;
  localparam int W  = 6;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic [N-1:0]   inst_vld, src_a_vld, src_b_vld, dst_vld;
  logic [N*W-1:0] src_a, src_b, dst;
  logic [N-1:0]   hazard;
  logic [N*N-1:0] producer;
  logic [CW-1:0]  issue_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  dep_issue_check uut (
    .inst_vld(inst_vld), .src_a(src_a), .src_a_vld(src_a_vld),
    .src_b(src_b), .src_b_vld(src_b_vld), .dst(dst), .dst_vld(dst_vld),
    .hazard(hazard), .producer(producer), .issue_cnt(issue_cnt)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_group();
    inst_vld = '0; src_a_vld = '0; src_b_vld = '0; dst_vld = '0;
    src_a = '0; src_b = '0; dst = '0;
  endtask

  task automatic set_slot(input int k, input bit iv,
                          input bit av, input logic [W-1:0] a,
                          input bit bv, input logic [W-1:0] b,
                          input bit dv, input logic [W-1:0] d);
    inst_vld[k] = iv; src_a_vld[k] = av; src_b_vld[k] = bv; dst_vld[k] = dv;
    src_a[k*W +: W] = a; src_b[k*W +: W] = b; dst[k*W +: W] = d;
  endtask

  // Nested-loop reference, then compare all outputs.
  task automatic compare_ref(input string req);
    logic [N-1:0]   e_hz;
    logic [N*N-1:0] e_pr;
    int             e_cnt;
    e_hz = '0; e_pr = '0; e_cnt = N;
    for (int i = 0; i < N; i++) begin
      int p;
      p = -1;
      for (int j = 0; j < i; j++) begin
        bit ma, mb;
        ma = src_a_vld[i] && (src_a[i*W +: W] == dst[j*W +: W]);
        mb = src_b_vld[i] && (src_b[i*W +: W] == dst[j*W +: W]);
        if (inst_vld[i] && inst_vld[j] && dst_vld[j] && (ma || mb)) p = j;
      end
      if (p >= 0) begin
        e_hz[i] = 1'b1;
        e_pr[i*N + p] = 1'b1;
      end
    end
    for (int i = N - 1; i >= 0; i--) if (e_hz[i]) e_cnt = i;
    #1;
    check(hazard == e_hz, {req, " hazard"}, 64'(hazard), 64'(e_hz));
    check(producer == e_pr, {req, " producer R6"}, 64'(producer), 64'(e_pr));
    check(int'(issue_cnt) == e_cnt, {req, " issue_cnt R7"}, 64'(issue_cnt), 64'(e_cnt));
  endtask

  initial begin
    rst_n = 1'b0;
    clear_group();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // Idle group: no hazard, full issue (R4, R7), settles without a clock (R8)
    #1;
    check(hazard == '0, "R4 idle hazard", 64'(hazard), 64'h0);
    check(int'(issue_cnt) == N, "R7 idle issue_cnt", 64'(issue_cnt), 64'(N));

    // R1 directed: slot2 first source reads slot0 dst
    @(negedge clk); clear_group();
    set_slot(0, 1, 0, 0, 0, 0, 1, 6'd9);
    set_slot(2, 1, 1, 6'd9, 0, 0, 0, 0);
    set_slot(1, 1, 1, 6'd3, 1, 6'd4, 1, 6'd5);
    #1;
    check(hazard == 4'b0100, "R1 hazard slot2", 64'(hazard), 64'h4);
    check(int'(issue_cnt) == 2, "R1 issue_cnt", 64'(issue_cnt), 64'd2);
    check(producer[2*N +: N] == 4'b0001, "R1 producer", 64'(producer[2*N +: N]), 64'h1);

    // R2 directed: slot3 second source reads slot1 dst
    @(negedge clk); clear_group();
    set_slot(1, 1, 0, 0, 0, 0, 1, 6'd17);
    set_slot(3, 1, 0, 0, 1, 6'd17, 0, 0);
    #1;
    check(hazard == 4'b1000, "R2 hazard slot3", 64'(hazard), 64'h8);
    check(producer[3*N +: N] == 4'b0010, "R2 producer", 64'(producer[3*N +: N]), 64'h2);

    // R3: slot0 reads its own and younger destinations
    @(negedge clk); clear_group();
    set_slot(0, 1, 1, 6'd7, 1, 6'd8, 1, 6'd7);
    set_slot(1, 1, 0, 0, 0, 0, 1, 6'd8);
    #1;
    check(hazard == '0, "R3 slot0 quiet", 64'(hazard), 64'h0);

    // R5: shared destinations (WAW) and younger writer of older source (WAR)
    @(negedge clk); clear_group();
    set_slot(0, 1, 1, 6'd2, 0, 0, 1, 6'd30);
    set_slot(1, 1, 0, 0, 0, 0, 1, 6'd30);
    set_slot(2, 1, 0, 0, 0, 0, 1, 6'd2);
    #1;
    check(hazard == '0, "R5 WAR/WAW ignored", 64'(hazard), 64'h0);
    check(int'(issue_cnt) == N, "R5 issue_cnt", 64'(issue_cnt), 64'(N));

    // R6: slot3 matches slots 0 and 2, youngest wins
    @(negedge clk); clear_group();
    set_slot(0, 1, 0, 0, 0, 0, 1, 6'd12);
    set_slot(2, 1, 0, 0, 0, 0, 1, 6'd40);
    set_slot(3, 1, 1, 6'd12, 1, 6'd40, 0, 0);
    #1;
    check(producer[3*N +: N] == 4'b0100, "R6 youngest producer",
          64'(producer[3*N +: N]), 64'h4);

    // R4 / R1 / R2 sweep: every reader/producer pair, each gating bit
    for (int i = 1; i < N; i++) begin
      for (int j = 0; j < i; j++) begin
        for (int s = 0; s < 2; s++) begin
          for (int g = 0; g < 5; g++) begin
            @(negedge clk); clear_group();
            set_slot(j, g != 1, 0, 0, 0, 0, g != 2, 6'd21);
            if (s == 0) set_slot(i, g != 3, g != 4, 6'd21, 0, 0, 0, 0);
            else        set_slot(i, g != 3, 0, 0, g != 4, 6'd21, 0, 0);
            compare_ref(s == 0 ? "R1 R4 sweep" : "R2 R4 sweep");
          end
        end
      end
    end

    // Random groups over a small register pool (R1 R2 R4 R5 R6 R7 R8)
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); clear_group();
      for (int k = 0; k < N; k++)
        set_slot(k, $urandom_range(0, 9) != 0,
                 $urandom_range(0, 4) != 0, W'($urandom_range(0, 3)),
                 $urandom_range(0, 4) != 0, W'($urandom_range(0, 3)),
                 $urandom_range(0, 4) != 0, W'($urandom_range(0, 3)));
      compare_ref("R1 R2 R4 R5 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule